// File: doc/BRIEF.md
# Port Change Detector

This block watches a small group of input pins and raises one shared change flag when any pin that has change detection turned on no longer matches a stored reference value. The pins first pass through a two-flop synchronizer. Each time software reads the port, the synchronized value is copied into the reference. A pin that then moves away from that copy sets the flag.

The flag stays set until software clears it, and a clear only takes effect once the mismatch is gone. The usual service sequence is therefore to read the port and then clear the flag. A separate enable bit gates the flag onto the interrupt request that goes to the interrupt controller.

The port read and the compare share a narrow window. A pin change that reaches the synchronizer output in the same cycle as a read is captured into the reference and is never flagged. The block reproduces this on purpose.

Top module: `ioc_detect`

## Requirements
- R1: After reset, `chg_flag_o`, `irq_o` and `port_data_o` are all 0, and the reference holds 0.
- R2: `port_data_o` shows the value of `pin_i` two clock edges after the pins are sampled (two synchronizer flops), bit i for pin i.
- R3: A cycle with `port_rd_i` high copies `port_data_o` into the reference at the next edge. A pin equal to its reference bit afterwards does not set the flag.
- R4: When bit i of `pin_en_i` is 1 and synchronized pin i differs from reference bit i, `chg_flag_o` is 1 one edge later. A pin change is therefore visible on the flag three edges after it is applied.
- R5: A pin whose bit in `pin_en_i` is 0 never sets the flag, whatever its reference bit holds.
- R6: While an enabled mismatch lasts outside a read cycle, the flag is set on every edge, so `chg_flag_clr_i` has no effect on it. Reading the port removes the mismatch, and the flag can then be cleared.
- R7: With no enabled mismatch, or in a read cycle, `chg_flag_clr_i` high clears the flag at the next edge. With neither a set nor a clear, the flag holds its value.
- R8: `irq_o` is 1 exactly when the flag is 1 and `irq_en_i` is 1. `irq_en_i` does not stop the flag from setting.
- R9: No flag set happens on an edge where `port_rd_i` is high. A change that first appears on `port_data_o` in the cycle of a read is therefore lost, and the flag stays 0 afterwards.
- R10: Mismatches on any number of enabled pins set the same single flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Raw asynchronous pin levels |
| pin_en_i | input | 4 | Per-pin change-detect enable, bit i for pin i |
| port_rd_i | input | 1 | Port read strobe; reloads the reference |
| chg_flag_clr_i | input | 1 | Software clear of the change flag |
| irq_en_i | input | 1 | Gates the flag onto the interrupt request |
| port_data_o | output | 4 | Synchronized pin values (port read data) |
| chg_flag_o | output | 1 | Shared change flag |
| irq_o | output | 1 | Interrupt request to the controller |

## Verification
The hardest case to reach is the lost change of R9. It occurs only when the read strobe is high in the one cycle in which a new pin level has just left the synchronizer. The bench applies the pin change on a falling edge and waits exactly two rising edges. It then raises the read strobe for one cycle and checks that the flag never rises. A second change, with no read in that window, confirms that the detector is still working.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

  // Enabled bits where the synchronized pin differs from the reference.
  function automatic logic [31:0] mismatch_vec(input logic [31:0] pins,
                                               input logic [31:0] refv,
                                               input logic [31:0] en);
    return (pins ^ refv) & en;
  endfunction

  // Next flag state: set beats clear, and a read cycle blocks the set.
  function automatic logic flag_next(input logic cur,
                                     input logic hit,
                                     input logic rd,
                                     input logic clr);
    logic nxt;
    if (hit && !rd)  nxt = 1'b1;
    else if (clr)    nxt = 1'b0;
    else             nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= '0;
      else        st[s] <= st[s-1];
    end
  end

  assign q_o = st[LAST];
endmodule

// File: rtl/ioc_ref_latch.sv
module ioc_ref_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/ioc_flag.sv
module ioc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic rd_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;

  always_comb flag_d = ioc_pkg::flag_next(flag_o, hit_i, rd_i, clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_d;
  end
endmodule

// File: rtl/ioc_detect.sv
module ioc_detect #(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  input  logic                port_rd_i,
  input  logic                chg_flag_clr_i,
  input  logic                irq_en_i,
  output logic [NUM_PINS-1:0] port_data_o,
  output logic                chg_flag_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] sync_q;
  logic [NUM_PINS-1:0] ref_q;
  logic [NUM_PINS-1:0] chg_vec;
  logic [31:0]         chg_wide;
  logic                chg_hit;

  ioc_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (sync_q)
  );

  ioc_ref_latch #(.W(NUM_PINS)) u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (port_rd_i),
    .d_i    (sync_q),
    .q_o    (ref_q)
  );

  assign chg_wide = ioc_pkg::mismatch_vec(32'(sync_q), 32'(ref_q), 32'(pin_en_i));
  assign chg_vec  = chg_wide[NUM_PINS-1:0];
  assign chg_hit  = |chg_vec;

  ioc_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (chg_hit),
    .rd_i   (port_rd_i),
    .clr_i  (chg_flag_clr_i),
    .flag_o (chg_flag_o)
  );

  assign port_data_o = sync_q;
  assign irq_o       = chg_flag_o & irq_en_i;
endmodule

// File: rtl/ioc_detect_chk.sv
module ioc_detect_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         port_rd_i,
  input logic         chg_flag_clr_i,
  input logic         chg_hit,
  input logic [W-1:0] ref_q,
  input logic [W-1:0] port_data_o,
  input logic         chg_flag_o
);
  // R4
  set_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_hit && !port_rd_i) |=> chg_flag_o);

  // R3
  ref_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd_i |=> (ref_q == $past(port_data_o)));

  // R9
  no_set_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_flag_o && port_rd_i) |=> !chg_flag_o);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag_clr_i && (!chg_hit || port_rd_i)) |=> !chg_flag_o);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag_o && !chg_flag_clr_i) |=> chg_flag_o);

  // R5
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_flag_o && !chg_hit) |=> !chg_flag_o);
endmodule

bind ioc_detect ioc_detect_chk #(.W(NUM_PINS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .port_rd_i      (port_rd_i),
  .chg_flag_clr_i (chg_flag_clr_i),
  .chg_hit        (chg_hit),
  .ref_q          (ref_q),
  .port_data_o    (port_data_o),
  .chg_flag_o     (chg_flag_o)
);

// File: tb/tb_ioc_detect.sv
module tb_ioc_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_i = '0;
  logic [3:0] pin_en_i = '0;
  logic       port_rd_i = 1'b0;
  logic       chg_flag_clr_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic [3:0] port_data_o;
  logic       chg_flag_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ioc_detect dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .pin_i          (pin_i),
    .pin_en_i       (pin_en_i),
    .port_rd_i      (port_rd_i),
    .chg_flag_clr_i (chg_flag_clr_i),
    .irq_en_i       (irq_en_i),
    .port_data_o    (port_data_o),
    .chg_flag_o     (chg_flag_o),
    .irq_o          (irq_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin_i = '0; pin_en_i = '0; port_rd_i = 1'b0;
    chg_flag_clr_i = 1'b0; irq_en_i = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 flag", chg_flag_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 data", port_data_o, 0);
  endtask

  task automatic t_sync();
    do_reset();
    pin_i = 4'hA;
    step(1); chk("R2 one edge", port_data_o, 0);
    step(1); chk("R2 two edges", port_data_o, 4'hA);
  endtask

  task automatic t_set_clear();
    do_reset();
    pin_en_i = 4'hF; pin_i = 4'h1;
    step(2); chk("R4 before third edge", chg_flag_o, 0);
    step(1); chk("R4 set", chg_flag_o, 1);
    port_rd_i = 1'b1; step(1); port_rd_i = 1'b0;
    chk("R7 hold over read", chg_flag_o, 1);
    chg_flag_clr_i = 1'b1; step(1); chg_flag_clr_i = 1'b0;
    chk("R7 clear", chg_flag_o, 0);
    step(3); chk("R3 reference matches", chg_flag_o, 0);
  endtask

  task automatic t_disabled();
    do_reset();
    pin_en_i = 4'b1110; pin_i = 4'b0001;
    step(5); chk("R5 disabled pin", chg_flag_o, 0);
    pin_i = 4'b0011;
    step(3); chk("R10 other pin sets shared flag", chg_flag_o, 1);
  endtask

  task automatic t_sticky();
    do_reset();
    pin_en_i = 4'hF; pin_i = 4'h4;
    step(3); chk("R6 set", chg_flag_o, 1);
    chg_flag_clr_i = 1'b1; step(1); chg_flag_clr_i = 1'b0;
    chk("R6 clear ignored during mismatch", chg_flag_o, 1);
    port_rd_i = 1'b1; chg_flag_clr_i = 1'b1; step(1);
    port_rd_i = 1'b0; chg_flag_clr_i = 1'b0;
    chk("R6 read plus clear", chg_flag_o, 0);
  endtask

  task automatic t_irq();
    do_reset();
    pin_en_i = 4'hF; pin_i = 4'h8;
    step(3);
    chk("R8 flag sets with irq off", chg_flag_o, 1);
    chk("R8 irq gated", irq_o, 0);
    irq_en_i = 1'b1; #1;
    chk("R8 irq on", irq_o, 1);
  endtask

  task automatic t_race();
    do_reset();
    pin_en_i = 4'hF; pin_i = 4'h2;
    step(2);
    port_rd_i = 1'b1; step(1); port_rd_i = 1'b0;
    step(3);
    chk("R9 change lost", chg_flag_o, 0);
    chk("R9 data", port_data_o, 4'h2);
    pin_i = 4'h0;
    step(3);
    chk("R9 later change seen", chg_flag_o, 1);
  endtask

  task automatic t_multi();
    do_reset();
    pin_en_i = 4'b1001; pin_i = 4'b1001;
    step(3); chk("R10 two pins", chg_flag_o, 1);
  endtask

  initial begin
    t_reset();
    t_sync();
    t_set_clear();
    t_disabled();
    t_sticky();
    t_irq();
    t_race();
    t_multi();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule